// File: doc/BRIEF.md
# Counter Access Permission Checker

This block decides whether an instruction touching one of the user-level counter addresses (cycle, time, instret and the 29 programmable event counters) may go ahead, or whether it must trap. It sees the requested address, whether the access writes, the current privilege level and the virtualization state. It also sees three counter-enable masks: one written by machine software, one by the hypervisor and one by the supervisor. From these it returns exactly one verdict for any address inside the counter window: allow, illegal-instruction or virtual-instruction.

Alongside the verdict, the block produces the value a read of the overflow-summary register returns at the current privilege level. It starts from the per-counter overflow flags and hides every bit that the enable masks do not grant to that level.

Both results are registered once. A request presented in one cycle is answered on the outputs after the next rising clock edge. Storing counter values, and decoding addresses outside the counter window, are handled elsewhere.

Top module: `cnt_access_guard`

## Requirements
- R1: An address in 0xC00..0xC1F is a counter access with index = address − 0xC00 (0 cycle, 1 time, 2 instret, 3..31 event counters). Any other address gives `rsp_hit` = 0 and all three verdict outputs 0.
- R2: Mode encoding is `priv` 2'b11 = M, 2'b01 = S, 2'b00 = U; 2'b10 is handled as U. `virt` selects VS/VU for S/U and is ignored in M. A read from M is always allowed, whatever the enables.
- R3: A write to any counter address raises illegal-instruction in every mode, including M, regardless of the enable masks.
- R4: A read from any mode below M whose machine-level enable bit for that counter is 0 raises illegal-instruction. This check takes priority over every other enable.
- R5: A read from VS or VU with the machine-level bit set and the hypervisor-level bit clear raises virtual-instruction.
- R6: With the machine-level bit set (and, in VU, the hypervisor-level bit set), a supervisor-level bit of 0 raises illegal-instruction in HU and virtual-instruction in VU.
- R7: A read is allowed when every enable required for the mode is set. HS needs machine-level. VS needs machine- and hypervisor-level. HU needs machine- and supervisor-level. VU needs all three.
- R8: Every response is registered one cycle after its request, with `rsp_valid` following `req_valid`. A hit carries exactly one verdict; no request carries none. Reset clears all outputs to 0.
- R9: The overflow view has bits 2:0 at 0. In M it shows overflow flags 31:3 unmasked.
- R10: In HS the view shows bit x only where machine-level enable bit x is 1. In VS it shows bit x only where both machine- and hypervisor-level bits x are 1.
- R11: In HU and VU the overflow view reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 12 | Register address of the access |
| req_write | input | 1 | Access attempts a write |
| priv | input | 2 | Current privilege level |
| virt | input | 1 | Virtualization active |
| men | input | 32 | Machine-level counter enable mask |
| hen | input | 32 | Hypervisor-level counter enable mask |
| sen | input | 32 | Supervisor-level counter enable mask |
| ovf_flags | input | 32 | Per-counter overflow flags (bits 2:0 unused) |
| rsp_valid | output | 1 | Verdict for last cycle's request |
| rsp_hit | output | 1 | Request fell inside the counter window |
| rsp_allow | output | 1 | Access may proceed |
| rsp_illegal | output | 1 | Raise illegal-instruction |
| rsp_virtual | output | 1 | Raise virtual-instruction |
| ovf_view | output | 32 | Overflow summary as seen from the current mode |

## Verification
The verdict outputs and the overflow view are due exactly one rising edge after the inputs that produced them. The view is recomputed every cycle, whether or not a request is valid. Each time the driver applies a stimulus on a falling edge, it also pushes the expected result into a queue. The monitor pops one entry 1 ns after each rising edge and compares all outputs at once. Because of this, every result is checked in the cycle it becomes due and never in a later one. Reset values are sampled the same way while reset is held.

// File: rtl/cnt_access_pkg.sv
`timescale 1ns/1ps
package cnt_access_pkg;

    typedef enum logic [2:0] {
        EM_M  = 3'd0,
        EM_HS = 3'd1,
        EM_HU = 3'd2,
        EM_VS = 3'd3,
        EM_VU = 3'd4
    } exec_mode_e;

    typedef enum logic [1:0] {
        VD_NONE    = 2'd0,
        VD_ALLOW   = 2'd1,
        VD_ILLEGAL = 2'd2,
        VD_VIRTUAL = 2'd3
    } verdict_e;

    typedef struct packed {
        logic valid;
        logic hit;
        logic allow;
        logic illegal;
        logic virt_instr;
    } guard_rsp_t;

    localparam logic [1:0] PRIV_M = 2'b11;
    localparam logic [1:0] PRIV_S = 2'b01;

    function automatic exec_mode_e decode_mode(input logic [1:0] priv, input logic virt);
        exec_mode_e m;
        if (priv == PRIV_M)      m = EM_M;
        else if (priv == PRIV_S) m = virt ? EM_VS : EM_HS;
        else                     m = virt ? EM_VU : EM_HU;
        return m;
    endfunction

endpackage

// File: rtl/cnt_addr_window.sv
`timescale 1ns/1ps
module cnt_addr_window #(
    parameter int          ADDR_W  = 12,
    parameter int          NUM_CNT = 32,
    parameter logic [11:0] BASE    = 12'hC00,
    localparam int         IDX_W   = $clog2(NUM_CNT)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] LO = {1'b0, ADDR_W'(BASE)};
    localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(NUM_CNT);

    logic [ADDR_W:0] addr_ext;
    logic [ADDR_W:0] offset;

    always_comb begin
        addr_ext = {1'b0, addr};
        offset   = addr_ext - LO;
        hit      = (addr_ext >= LO) && (addr_ext < HI);
        idx      = offset[IDX_W-1:0];
    end
endmodule

// File: rtl/cnt_perm_eval.sv
`timescale 1ns/1ps
module cnt_perm_eval
    import cnt_access_pkg::*;
#(
    parameter int  NUM_CNT = 32,
    localparam int IDX_W   = $clog2(NUM_CNT)
) (
    input  exec_mode_e         mode,
    input  logic               hit,
    input  logic               write,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_CNT-1:0] men,
    input  logic [NUM_CNT-1:0] hen,
    input  logic [NUM_CNT-1:0] sen,
    output verdict_e           verdict
);
    logic m_ok, h_ok, s_ok;

    always_comb begin
        m_ok = men[idx];
        h_ok = hen[idx];
        s_ok = sen[idx];
        verdict = VD_ALLOW;
        if (!hit) begin
            verdict = VD_NONE;
        end else if (write) begin
            verdict = VD_ILLEGAL;
        end else begin
            unique case (mode)
                EM_M:  verdict = VD_ALLOW;
                EM_HS: verdict = m_ok ? VD_ALLOW : VD_ILLEGAL;
                EM_VS: begin
                    if (!m_ok)      verdict = VD_ILLEGAL;
                    else if (!h_ok) verdict = VD_VIRTUAL;
                end
                EM_HU: begin
                    if (!m_ok || !s_ok) verdict = VD_ILLEGAL;
                end
                EM_VU: begin
                    if (!m_ok)      verdict = VD_ILLEGAL;
                    else if (!h_ok) verdict = VD_VIRTUAL;
                    else if (!s_ok) verdict = VD_VIRTUAL;
                end
                default: verdict = VD_ILLEGAL;
            endcase
        end
    end
endmodule

// File: rtl/cnt_ovf_view.sv
`timescale 1ns/1ps
module cnt_ovf_view
    import cnt_access_pkg::*;
#(
    parameter int NUM_CNT   = 32,
    parameter int FIRST_HPM = 3
) (
    input  exec_mode_e         mode,
    input  logic [NUM_CNT-1:0] flags,
    input  logic [NUM_CNT-1:0] men,
    input  logic [NUM_CNT-1:0] hen,
    output logic [NUM_CNT-1:0] view
);
    logic [NUM_CNT-1:0] grant;

    always_comb begin
        unique case (mode)
            EM_M:    grant = '1;
            EM_HS:   grant = men;
            EM_VS:   grant = men & hen;
            default: grant = '0;
        endcase
    end

    for (genvar b = 0; b < NUM_CNT; b++) begin : g_bit
        if (b < FIRST_HPM) begin : g_fixed
            assign view[b] = 1'b0;
        end else begin : g_event
            assign view[b] = flags[b] & grant[b];
        end
    end
endmodule

// File: rtl/cnt_access_guard.sv
`timescale 1ns/1ps
module cnt_access_guard
    import cnt_access_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_CNT   = 32,
    parameter int          FIRST_HPM = 3,
    parameter logic [11:0] BASE      = 12'hC00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic [NUM_CNT-1:0] men,
    input  logic [NUM_CNT-1:0] hen,
    input  logic [NUM_CNT-1:0] sen,
    input  logic [NUM_CNT-1:0] ovf_flags,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_allow,
    output logic               rsp_illegal,
    output logic               rsp_virtual,
    output logic [NUM_CNT-1:0] ovf_view
);
    localparam int IDX_W = $clog2(NUM_CNT);

    exec_mode_e         mode;
    logic               win_hit;
    logic [IDX_W-1:0]   win_idx;
    verdict_e           verdict;
    logic [NUM_CNT-1:0] view_c;

    guard_rsp_t         rsp_d, rsp_q;
    logic [NUM_CNT-1:0] ovf_d, ovf_q;

    assign mode = decode_mode(priv, virt);

    cnt_addr_window #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .BASE(BASE)) u_window (
        .addr (req_addr),
        .hit  (win_hit),
        .idx  (win_idx)
    );

    cnt_perm_eval #(.NUM_CNT(NUM_CNT)) u_perm (
        .mode    (mode),
        .hit     (win_hit),
        .write   (req_write),
        .idx     (win_idx),
        .men     (men),
        .hen     (hen),
        .sen     (sen),
        .verdict (verdict)
    );

    cnt_ovf_view #(.NUM_CNT(NUM_CNT), .FIRST_HPM(FIRST_HPM)) u_ovf (
        .mode  (mode),
        .flags (ovf_flags),
        .men   (men),
        .hen   (hen),
        .view  (view_c)
    );

    always_comb begin
        rsp_d            = '0;
        rsp_d.valid      = req_valid;
        rsp_d.hit        = req_valid && win_hit;
        rsp_d.allow      = req_valid && (verdict == VD_ALLOW);
        rsp_d.illegal    = req_valid && (verdict == VD_ILLEGAL);
        rsp_d.virt_instr = req_valid && (verdict == VD_VIRTUAL);
        ovf_d            = view_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
            ovf_q <= '0;
        end else begin
            rsp_q <= rsp_d;
            ovf_q <= ovf_d;
        end
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_hit     = rsp_q.hit;
    assign rsp_allow   = rsp_q.allow;
    assign rsp_illegal = rsp_q.illegal;
    assign rsp_virtual = rsp_q.virt_instr;
    assign ovf_view    = ovf_q;

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> !rsp_allow && !rsp_illegal && !rsp_virtual); // R1
    AST_M_READ_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && win_hit && !req_write && mode == EM_M |=> rsp_allow); // R2
    AST_WRITE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && win_hit && req_write |=> rsp_illegal && !rsp_allow); // R3
    AST_MEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && win_hit && mode != EM_M && !men[win_idx] |=> rsp_illegal); // R4
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $countones({rsp_allow, rsp_illegal, rsp_virtual}) == 1); // R8
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R8
    AST_OVF_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_view[FIRST_HPM-1:0] == '0); // R9
    AST_OVF_MEN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        mode != EM_M |=> (ovf_view & ~$past(men)) == '0); // R10
    AST_OVF_USER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mode == EM_HU || mode == EM_VU |=> ovf_view == '0); // R11
endmodule

// File: tb/cnt_access_guard_bench.sv
`timescale 1ns/1ps
module cnt_access_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  priv = '0;
    logic        virt = 1'b0;
    logic [31:0] men = '0, hen = '0, sen = '0, ovf_flags = '0;
    logic        rsp_valid, rsp_hit, rsp_allow, rsp_illegal, rsp_virtual;
    logic [31:0] ovf_view;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [4:0]  flags;  // valid, hit, allow, illegal, virtual
        logic [31:0] ovf;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    always #2.5 clk = ~clk;

    cnt_access_guard u_cnt_access_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .priv(priv), .virt(virt), .men(men), .hen(hen),
        .sen(sen), .ovf_flags(ovf_flags), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_allow(rsp_allow), .rsp_illegal(rsp_illegal), .rsp_virtual(rsp_virtual),
        .ovf_view(ovf_view)
    );

    // reference model written from the requirements
    function automatic exp_t model(input logic v, input logic [11:0] a, input logic w,
                                   input logic [1:0] p, input logic vt,
                                   input logic [31:0] m, input logic [31:0] h,
                                   input logic [31:0] s, input logic [31:0] f,
                                   input string tag);
        exp_t e;
        logic hit, isM, isS, al, il, vi;
        int i;
        hit = (a >= 12'hC00) && (a <= 12'hC1F);
        i   = int'(a[4:0]);
        isM = (p == 2'b11);
        isS = (p == 2'b01);
        al = 0; il = 0; vi = 0;
        if (hit) begin
            if (w) il = 1;
            else if (isM) al = 1;
            else if (!m[i]) il = 1;
            else if (vt && !h[i]) vi = 1;
            else if (!isS && !s[i]) begin
                if (vt) vi = 1; else il = 1;
            end else al = 1;
        end
        e.flags = {v, v & hit, v & al, v & il, v & vi};
        if (isM)           e.ovf = f & 32'hFFFF_FFF8;
        else if (isS && !vt) e.ovf = f & m & 32'hFFFF_FFF8;
        else if (isS)      e.ovf = f & m & h & 32'hFFFF_FFF8;
        else               e.ovf = 32'h0;
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(input logic [11:0] a, input logic w, input logic [1:0] p,
                         input logic vt, input logic [31:0] m, input logic [31:0] h,
                         input logic [31:0] s, input logic [31:0] f, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; priv = p; virt = vt;
        men = m; hen = h; sen = s; ovf_flags = f;
        exp_q.push_back(model(1'b1, a, w, p, vt, m, h, s, f, tag));
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        exp_q.push_back(model(1'b0, req_addr, req_write, priv, virt, men, hen, sen, ovf_flags, tag));
    endtask

    // monitor: each entry is due one rising edge after it was driven
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            checks++;
            if ({rsp_valid, rsp_hit, rsp_allow, rsp_illegal, rsp_virtual} !== cur.flags
                || ovf_view !== cur.ovf) begin
                errors++;
                $display("FAIL %s: got v/h/a/i/x=%b ovf=%h, expected %b ovf=%h", cur.tag,
                         {rsp_valid, rsp_hit, rsp_allow, rsp_illegal, rsp_virtual}, ovf_view,
                         cur.flags, cur.ovf);
            end
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [1:0] PM = 2'b11, PS = 2'b01, PU = 2'b00;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    initial begin
        req_valid = 1'b1; req_addr = 12'hC00; ovf_flags = ONES; priv = PM;
        repeat (3) begin
            @(posedge clk); #1;
            checks++;
            if ({rsp_valid, rsp_hit, rsp_allow, rsp_illegal, rsp_virtual, ovf_view} !== '0) begin
                errors++;
                $display("FAIL R8 reset: got %b/%h, expected 0/0",
                         {rsp_valid, rsp_hit, rsp_allow, rsp_illegal, rsp_virtual}, ovf_view);
            end
        end
        @(negedge clk); req_valid = 1'b0; rst_n = 1'b1;

        // R1 window edges
        drive(12'hBFF, 0, PM, 0, ONES, ONES, ONES, ONES, "R1");
        drive(12'hC20, 0, PU, 0, 0, 0, 0, ONES, "R1");
        drive(12'hC00, 0, PM, 0, 0, 0, 0, 0, "R1");
        drive(12'hC1F, 0, PS, 0, 32'h8000_0000, 0, 0, 0, "R1");
        // R2 M always allowed, virt ignored in M
        drive(12'hC05, 0, PM, 0, 0, 0, 0, 0, "R2");
        drive(12'hC02, 0, PM, 1, 0, 0, 0, 0, "R2");
        // R3 writes
        drive(12'hC00, 1, PM, 0, ONES, ONES, ONES, 0, "R3");
        drive(12'hC10, 1, PU, 1, ONES, ONES, ONES, 0, "R3");
        // R4 machine-level bit clear wins
        drive(12'hC03, 0, PS, 0, ~32'h8, ONES, ONES, 0, "R4");
        drive(12'hC03, 0, PS, 1, ~32'h8, ONES, ONES, 0, "R4");
        drive(12'hC04, 0, PU, 1, ~32'h10, 0, 0, 0, "R4");
        // R5 hypervisor-level clear
        drive(12'hC01, 0, PS, 1, ONES, ~32'h2, ONES, 0, "R5");
        drive(12'hC01, 0, PU, 1, ONES, ~32'h2, 0, 0, "R5");
        // R6 supervisor-level clear; priv 2'b10 handled as U
        drive(12'hC07, 0, PU, 0, ONES, ONES, ~32'h80, 0, "R6");
        drive(12'hC07, 0, PU, 1, ONES, ONES, ~32'h80, 0, "R6");
        drive(12'hC07, 0, 2'b10, 0, ONES, ONES, ~32'h80, 0, "R6");
        // R7 allows with the needed enables only
        drive(12'hC09, 0, PS, 0, 32'h200, 0, 0, 0, "R7");
        drive(12'hC09, 0, PS, 1, 32'h200, 32'h200, 0, 0, "R7");
        drive(12'hC09, 0, PU, 0, 32'h200, 0, 32'h200, 0, "R7");
        drive(12'hC09, 0, PU, 1, 32'h200, 32'h200, 32'h200, 0, "R7");
        // R8 no request, no verdict
        idle("R8");
        // R9..R11 overflow view
        drive(12'h300, 0, PM, 0, 0, 0, 0, ONES, "R9");
        drive(12'h300, 0, PS, 0, 32'h0000_FF0F, 0, 0, ONES, "R10");
        drive(12'h300, 0, PS, 1, 32'hFF00_FF00, 32'hF0F0_F0F0, 0, ONES, "R10");
        drive(12'h300, 0, PU, 0, ONES, ONES, ONES, ONES, "R11");
        drive(12'h300, 0, PU, 1, ONES, ONES, ONES, ONES, "R11");

        for (int n = 0; n < 400; n++) begin
            drive(12'hBF8 + 12'($urandom % 48), ($urandom % 8) == 0, 2'($urandom),
                  1'($urandom), $urandom, $urandom, $urandom, $urandom, "mixed");
        end
        idle("R8");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule